// File: doc/BRIEF.md
# Vector-Length Loop Issue Sequencer

This block is the instruction-issue control of a scalar core that understands a vector-length prefix. It fetches instruction words one at a time. When a word turns out to be a prefix, it fetches and decodes the following operation word before anything is issued. The prefix says which of the three operands (destination, first source, second source) are vectors. If any operand is a vector, the sequencer issues the same operation once per element. Each element waits for the execution unit to report completion before the next one starts. A step counter in the vector state is added to the base register number of every vector operand.

The step counter acts as a sub-program-counter. On exception entry the sequencer copies the vector length, the step and the start address of the current instruction into save registers, then jumps to a fixed handler address. On exception return it restores all three. It then fetches the interrupted instruction again, prefix included, and carries on from the saved element. A separate write port sets the vector length. The execution unit, the register file and the memory sit outside the block.

Top module: `vlIssueSeq`

## Requirements
- R1: A fetched word whose bits [31:28] equal 4'b1000 is a prefix, and its bits [2:0] mark the operands as vectors (bit 2 destination, bit 1 first source, bit 0 second source). After a prefix the next word is fetched and decoded before any issue, and `issueValid` is never high while `fetchReq` is high.
- R2: An issued element keeps `issueValid` and its operand outputs steady until a cycle with `execDone` high. That cycle completes the element, and `issueValid` is low in the cycle after it.
- R3: An operation with no vector operand issues exactly once, whatever the vector length, with step 0.
- R4: With at least one vector operand and a nonzero vector length VL, elements 0 to VL-1 are issued in ascending step order. The instruction ends after element VL-1 completes.
- R5: When an instruction ends, `curStep` returns to 0.
- R6: An operation word carries the destination in bits [27:21], the first source in [20:14], the second source in [13:7] and the opcode in [6:0]. A vector operand's index output is its base plus the current step, modulo 128. A scalar operand's index output is its base alone.
- R7: A pulse on `setVlEn` writes `setVlVal` into the vector length, and `curVl` shows it from the next cycle.
- R8: On exception entry (`excEntry` high) the vector length, the step and the start address of the current instruction are saved. The fetch address then becomes the handler address (0x100 by default) and the step becomes 0.
- R9: An `excRet` pulse while waiting on a fetch restores the saved vector length and step. Fetching resumes at the saved start address, so a prefixed instruction is fetched again from its prefix and continues from the saved step.
- R10: A vector instruction with VL 0 issues nothing, and the sequencer moves on to the next instruction.
- R11: `excReq` is acted on only between elements or before the first element. A request raised while an element waits for completion is taken after that element completes, so the saved step names the first element not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | output | 1 | Fetch request for the word at `fetchAddr` |
| fetchAddr | output | 16 | Word address being fetched |
| fetchValid | input | 1 | `fetchWord` holds the requested word this cycle |
| fetchWord | input | 32 | Fetched instruction word |
| issueValid | output | 1 | An element is issued and awaiting completion |
| issueOp | output | 7 | Opcode of the issued operation |
| rtIdx | output | 7 | Destination register index for this element |
| raIdx | output | 7 | First source register index for this element |
| rbIdx | output | 7 | Second source register index for this element |
| execDone | input | 1 | Execution unit completes the issued element |
| excReq | input | 1 | Exception request |
| excEntry | output | 1 | Exception taken this cycle |
| excRet | input | 1 | Return from exception |
| setVlEn | input | 1 | Write strobe for the vector length |
| setVlVal | input | 7 | New vector length |
| curVl | output | 7 | Current vector length |
| curStep | output | 7 | Current element step |

## Verification
The two functions that can coincide are an exception request and an element still waiting for completion. The bench raises `excReq` in the first cycle that element 1 of a five-element loop is issued under a three-cycle execution latency. It then judges three things: the request must not be taken until that element completes, `excEntry` must find exactly two completed elements and a step of 2, and after a handler instruction and `excRet` only elements 2 to 4 may be issued, with the vector length the handler overwrote put back.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

  localparam int unsigned OpW = 7;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_BOUND,
    ST_EXEC
  } seqState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic latchPrefix;
    logic latchOp;
    logic pcInc;
    logic stepInc;
    logic instDone;
    logic excSave;
    logic excRestore;
  } seqStrobe_t;

endpackage

// File: rtl/vlseq_ctrl.sv
module vlseq_ctrl
  import vlseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic       prefixSeen,
  input  logic       anyVec,
  input  logic       vlZero,
  input  logic       lastElem,
  input  logic       execDone,
  input  logic       excReq,
  input  logic       excRet,
  output seqStrobe_t strobe,
  output logic       fetchReq,
  output logic       issueValid,
  output logic       excEntry
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe     = '0;
    fetchReq   = 1'b0;
    issueValid = 1'b0;
    excEntry   = 1'b0;
    stateNxt   = state;
    unique case (state)
      ST_FETCH: begin
        if (excRet) begin
          strobe.excRestore = 1'b1;
        end else begin
          fetchReq = 1'b1;
          if (fetchValid) begin
            strobe.pcInc = 1'b1;
            if (prefixSeen) begin
              strobe.latchPrefix = 1'b1;
            end else begin
              strobe.latchOp = 1'b1;
              stateNxt       = ST_BOUND;
            end
          end
        end
      end
      // element boundary: the only place an exception is taken
      ST_BOUND: begin
        if (excReq) begin
          excEntry       = 1'b1;
          strobe.excSave = 1'b1;
          stateNxt       = ST_FETCH;
        end else if (anyVec && vlZero) begin
          strobe.instDone = 1'b1;
          stateNxt        = ST_FETCH;
        end else begin
          stateNxt = ST_EXEC;
        end
      end
      ST_EXEC: begin
        issueValid = 1'b1;
        if (execDone) begin
          if (!anyVec || lastElem) begin
            strobe.instDone = 1'b1;
            stateNxt        = ST_FETCH;
          end else begin
            strobe.stepInc = 1'b1;
            stateNxt       = ST_BOUND;
          end
        end
      end
      default: stateNxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/vlseq_dp.sv
module vlseq_dp
  import vlseq_pkg::*;
#(
  parameter int unsigned PcW        = 16,
  parameter int unsigned StepW      = 7,
  parameter int unsigned RegW       = 7,
  parameter int unsigned ExcVecAddr = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [31:0]      fetchWord,
  input  logic             setVlEn,
  input  logic [StepW-1:0] setVlVal,
  output logic             prefixSeen,
  output logic             anyVec,
  output logic             vlZero,
  output logic             lastElem,
  output logic [PcW-1:0]   fetchAddr,
  output logic [OpW-1:0]   issueOp,
  output logic [RegW-1:0]  rtIdx,
  output logic [RegW-1:0]  raIdx,
  output logic [RegW-1:0]  rbIdx
  ,output logic [StepW-1:0] curVl
  ,output logic [StepW-1:0] curStep
);

  localparam int unsigned NumOpnd = 3;
  localparam int unsigned RbLsb   = OpW;
  localparam int unsigned RaLsb   = OpW + RegW;
  localparam int unsigned RtLsb   = OpW + 2 * RegW;
  localparam logic [3:0]  PreTag  = 4'b1000;
  localparam logic [PcW-1:0] ExcPc = PcW'(ExcVecAddr);

  logic [PcW-1:0]     pc, instPc, savPc;
  logic [StepW-1:0]   vl, step, savVl, savStep;
  logic [NumOpnd-1:0] vecFl;
  logic [OpW-1:0]     opR;
  logic [RegW-1:0]    regBase [NumOpnd];
  logic [RegW-1:0]    regIdx  [NumOpnd];
  logic [StepW:0]     stepPlus;

  assign prefixSeen = (fetchWord[31:28] == PreTag);
  assign anyVec     = |vecFl;
  assign vlZero     = (vl == '0);
  assign stepPlus   = {1'b0, step} + {{StepW{1'b0}}, 1'b1};
  assign lastElem   = (stepPlus >= {1'b0, vl});

  // operand 0: second source, 1: first source, 2: destination
  for (genvar g = 0; g < NumOpnd; g++) begin : g_idx
    assign regIdx[g] = regBase[g] + (vecFl[g] ? RegW'(step) : '0);
  end

  assign rbIdx     = regIdx[0];
  assign raIdx     = regIdx[1];
  assign rtIdx     = regIdx[2];
  assign issueOp   = opR;
  assign fetchAddr = pc;
  assign curVl     = vl;
  assign curStep   = step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      instPc  <= '0;
      savPc   <= '0;
      vl      <= '0;
      step    <= '0;
      savVl   <= '0;
      savStep <= '0;
      vecFl   <= '0;
      opR     <= '0;
      for (int i = 0; i < NumOpnd; i++) regBase[i] <= '0;
    end else begin
      if (strobe.pcInc)       pc <= pc + 1'b1;
      if (strobe.latchPrefix) vecFl <= fetchWord[NumOpnd-1:0];
      if (strobe.latchOp) begin
        regBase[0] <= fetchWord[RbLsb +: RegW];
        regBase[1] <= fetchWord[RaLsb +: RegW];
        regBase[2] <= fetchWord[RtLsb +: RegW];
        opR        <= fetchWord[OpW-1:0];
      end
      if (strobe.stepInc) step <= step + 1'b1;
      if (strobe.instDone) begin
        step   <= '0;
        vecFl  <= '0;
        instPc <= pc;
      end
      if (strobe.excSave) begin
        savPc   <= instPc;
        savVl   <= vl;
        savStep <= step;
        pc      <= ExcPc;
        instPc  <= ExcPc;
        step    <= '0;
        vecFl   <= '0;
      end
      if (strobe.excRestore) begin
        pc     <= savPc;
        instPc <= savPc;
        vl     <= savVl;
        step   <= savStep;
        vecFl  <= '0;
      end else if (setVlEn) begin
        vl <= setVlVal;
      end
    end
  end

endmodule

// File: rtl/vlIssueSeq.sv
module vlIssueSeq
  import vlseq_pkg::*;
#(
  parameter int unsigned PcW        = 16,
  parameter int unsigned StepW      = 7,
  parameter int unsigned RegW       = 7,
  parameter int unsigned ExcVecAddr = 256
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             fetchReq,
  output logic [PcW-1:0]   fetchAddr,
  input  logic             fetchValid,
  input  logic [31:0]      fetchWord,
  output logic             issueValid,
  output logic [OpW-1:0]   issueOp,
  output logic [RegW-1:0]  rtIdx,
  output logic [RegW-1:0]  raIdx,
  output logic [RegW-1:0]  rbIdx,
  input  logic             execDone,
  input  logic             excReq,
  output logic             excEntry,
  input  logic             excRet,
  input  logic             setVlEn,
  input  logic [StepW-1:0] setVlVal,
  output logic [StepW-1:0] curVl,
  output logic [StepW-1:0] curStep
);

  seqStrobe_t strobe;
  logic prefixSeen, anyVec, vlZero, lastElem;

  vlseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .prefixSeen(prefixSeen),
    .anyVec(anyVec), .vlZero(vlZero), .lastElem(lastElem), .execDone(execDone),
    .excReq(excReq), .excRet(excRet), .strobe(strobe), .fetchReq(fetchReq),
    .issueValid(issueValid), .excEntry(excEntry)
  );

  vlseq_dp #(
    .PcW(PcW), .StepW(StepW), .RegW(RegW), .ExcVecAddr(ExcVecAddr)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchWord(fetchWord),
    .setVlEn(setVlEn), .setVlVal(setVlVal), .prefixSeen(prefixSeen),
    .anyVec(anyVec), .vlZero(vlZero), .lastElem(lastElem),
    .fetchAddr(fetchAddr), .issueOp(issueOp), .rtIdx(rtIdx), .raIdx(raIdx),
    .rbIdx(rbIdx), .curVl(curVl), .curStep(curStep)
  );

endmodule

// File: rtl/vlIssueSeq_chk.sv
module vlIssueSeq_chk
  import vlseq_pkg::*;
#(
  parameter int unsigned PcW        = 16,
  parameter int unsigned StepW      = 7,
  parameter int unsigned RegW       = 7,
  parameter int unsigned ExcVecAddr = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchReq,
  input logic [PcW-1:0]   fetchAddr,
  input logic             issueValid,
  input logic             execDone,
  input logic [OpW-1:0]   issueOp,
  input logic [RegW-1:0]  rtIdx,
  input logic [RegW-1:0]  raIdx,
  input logic [RegW-1:0]  rbIdx,
  input logic             excEntry,
  input logic [StepW-1:0] curVl,
  input logic [StepW-1:0] curStep
);

  a_r1_no_issue_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> !issueValid);

  a_r2_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !execDone |=> issueValid && $stable(issueOp) &&
      $stable(rtIdx) && $stable(raIdx) && $stable(rbIdx));

  a_r2_gap_after_done: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && execDone |=> !issueValid);

  a_r4_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && (curVl != '0) |-> curStep < curVl);

  a_r8_handler_entry: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |=> (fetchAddr == PcW'(ExcVecAddr)) && (curStep == '0));

  a_r11_not_mid_element: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |-> !issueValid);

endmodule

bind vlIssueSeq vlIssueSeq_chk #(
  .PcW(PcW), .StepW(StepW), .RegW(RegW), .ExcVecAddr(ExcVecAddr)
) chk_i (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .issueValid(issueValid), .execDone(execDone), .issueOp(issueOp),
  .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx), .excEntry(excEntry),
  .curVl(curVl), .curStep(curStep)
);

// File: tb/vlIssueSeq_tb.sv
module vlIssueSeq_tb_top;

  localparam int unsigned EXC = 256;

  typedef struct packed {
    logic [6:0] vl;
    logic       pre;
    logic [2:0] fl;
    logic [6:0] rt;
    logic [6:0] ra;
    logic [6:0] rb;
    logic [6:0] op;
    logic [3:0] lat;
    logic [7:0] nExp;
  } tv_t;

  localparam int NV = 7;
  localparam tv_t TV [NV] = '{
    '{7'd4, 1'b1, 3'd7, 7'd10,  7'd20,  7'd30,  7'd5,  4'd1, 8'd4},
    '{7'd3, 1'b1, 3'd4, 7'd5,   7'd6,   7'd7,   7'd9,  4'd0, 8'd3},
    '{7'd5, 1'b0, 3'd0, 7'd1,   7'd2,   7'd3,   7'd11, 4'd2, 8'd1},
    '{7'd0, 1'b1, 3'd7, 7'd8,   7'd9,   7'd10,  7'd12, 4'd0, 8'd0},
    '{7'd3, 1'b1, 3'd7, 7'd126, 7'd127, 7'd125, 7'd13, 4'd1, 8'd3},
    '{7'd1, 1'b1, 3'd3, 7'd40,  7'd41,  7'd42,  7'd14, 4'd0, 8'd1},
    '{7'd6, 1'b1, 3'd2, 7'd0,   7'd100, 7'd50,  7'd15, 4'd0, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq, fetchValid, issueValid, execDone, excEntry;
  logic [15:0] fetchAddr;
  logic [31:0] fetchWord;
  logic [6:0]  issueOp, rtIdx, raIdx, rbIdx, curVl, curStep;
  logic        excReq = 1'b0, excRet = 1'b0, setVlEn = 1'b0;
  logic [6:0]  setVlVal = '0;

  logic [31:0] imem [512];
  logic [15:0] winLo = '0, winHi = '0, hLo = '0, hHi = '0;
  int          lat = 0;
  logic [3:0]  waitCnt = '0;

  int          checks = 0, errors = 0;
  int          logCnt = 0, curDur = 0;
  logic [6:0]  lRt [256], lRa [256], lRb [256], lOp [256];
  int          lDur [256];

  always #10 clk = ~clk;

  assign fetchValid = fetchReq &&
    ((fetchAddr >= winLo && fetchAddr < winHi) || (fetchAddr >= hLo && fetchAddr < hHi));
  assign fetchWord = imem[fetchAddr[8:0]];
  assign execDone  = issueValid && (int'(waitCnt) >= lat);

  always @(posedge clk) waitCnt <= (issueValid && !execDone) ? waitCnt + 4'd1 : 4'd0;

  always @(negedge clk) begin
    if (rstN && issueValid) begin
      curDur = curDur + 1;
      if (execDone) begin
        lRt[logCnt]  = rtIdx;
        lRa[logCnt]  = raIdx;
        lRb[logCnt]  = rbIdx;
        lOp[logCnt]  = issueOp;
        lDur[logCnt] = curDur;
        logCnt = logCnt + 1;
        curDur = 0;
      end
    end
  end

  vlIssueSeq dut_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchWord(fetchWord), .issueValid(issueValid),
    .issueOp(issueOp), .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx),
    .execDone(execDone), .excReq(excReq), .excEntry(excEntry), .excRet(excRet),
    .setVlEn(setVlEn), .setVlVal(setVlVal), .curVl(curVl), .curStep(curStep)
  );

  function automatic logic [31:0] mkOp(logic [6:0] rt, logic [6:0] ra, logic [6:0] rb, logic [6:0] op);
    return {4'b0000, rt, ra, rb, op};
  endfunction

  function automatic logic [31:0] mkPre(logic [2:0] fl);
    return {4'b1000, 25'd0, fl};
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setVl(input logic [6:0] v);
    @(negedge clk);
    setVlEn  = 1'b1;
    setVlVal = v;
    @(posedge clk);
    @(negedge clk);
    setVlEn = 1'b0;
    chkEq("R7 vector length written", int'(curVl), int'(v));
  endtask

  task automatic waitFetchAt(input logic [15:0] a);
    forever begin
      @(negedge clk);
      if (fetchReq && fetchAddr == a) break;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finishRun();
  end

  initial begin
    int addr;
    addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R5 reset step", int'(curStep), 0);
    chkEq("R7 reset vector length", int'(curVl), 0);
    chkEq("R1 reset fetch request", int'(fetchReq), 1);
    chkEq("R1 reset fetch address", int'(fetchAddr), 0);
    chkEq("R2 reset no issue", int'(issueValid), 0);
    chkEq("R8 reset no exception", int'(excEntry), 0);

    // table of instructions: R1 R3 R4 R6 R10
    for (int k = 0; k < NV; k++) begin
      automatic tv_t t = TV[k];
      automatic int len = 0;
      automatic int base;
      automatic int n;
      winLo = 16'(addr);
      winHi = 16'(addr);
      setVl(t.vl);
      lat = int'(t.lat);
      if (t.pre) begin
        imem[addr] = mkPre(t.fl);
        len = 1;
      end
      imem[addr + len] = mkOp(t.rt, t.ra, t.rb, t.op);
      len++;
      base  = logCnt;
      winHi = 16'(addr + len);
      waitFetchAt(16'(addr + len));
      n = logCnt - base;
      chkEq("R3 R4 R10 element count", n, int'(t.nExp));
      if (n == int'(t.nExp)) begin
        for (int i = 0; i < n; i++) begin
          automatic int sRt = (t.pre && t.fl[2]) ? i : 0;
          automatic int sRa = (t.pre && t.fl[1]) ? i : 0;
          automatic int sRb = (t.pre && t.fl[0]) ? i : 0;
          chkEq("R6 destination index", int'(lRt[base+i]), (int'(t.rt) + sRt) % 128);
          chkEq("R6 first source index", int'(lRa[base+i]), (int'(t.ra) + sRa) % 128);
          chkEq("R6 second source index", int'(lRb[base+i]), (int'(t.rb) + sRb) % 128);
          chkEq("R1 opcode after prefix", int'(lOp[base+i]), int'(t.op));
          chkEq("R2 held until done", lDur[base+i], lat + 1);
        end
      end
      chkEq("R5 step cleared at end", int'(curStep), 0);
      addr += len;
    end

    // exception raised while element 1 waits: R8 R9 R11
    begin
      automatic int a0 = addr;
      automatic int base;
      setVl(7'd5);
      winLo = 16'(a0);
      winHi = 16'(a0);
      imem[a0]     = mkPre(3'd7);
      imem[a0 + 1] = mkOp(7'd40, 7'd50, 7'd60, 7'd20);
      imem[EXC]    = mkOp(7'd1, 7'd2, 7'd3, 7'd21);
      hLo  = 16'(EXC);
      hHi  = 16'(EXC + 1);
      lat  = 3;
      base = logCnt;
      winHi = 16'(a0 + 2);
      forever begin
        @(negedge clk);
        if (logCnt - base == 1 && issueValid && !execDone) break;
      end
      excReq = 1'b1;
      forever begin
        @(negedge clk);
        if (excEntry) break;
      end
      chkEq("R11 element in flight completes first", logCnt - base, 2);
      chkEq("R11 saved step is first open element", int'(curStep), 2);
      @(posedge clk);
      @(negedge clk);
      excReq = 1'b0;
      chkEq("R8 fetch at handler", int'(fetchAddr), int'(EXC));
      chkEq("R8 step zero in handler", int'(curStep), 0);
      waitFetchAt(16'(EXC + 1));
      chkEq("R3 handler scalar issues once", logCnt - base, 3);
      chkEq("R3 handler destination", int'(lRt[base+2]), 1);
      chkEq("R3 handler second source", int'(lRb[base+2]), 3);
      setVl(7'd2);
      @(negedge clk);
      excRet = 1'b1;
      @(posedge clk);
      @(negedge clk);
      excRet = 1'b0;
      chkEq("R9 refetch from prefix", int'(fetchAddr), a0);
      chkEq("R9 step restored", int'(curStep), 2);
      chkEq("R9 vector length restored", int'(curVl), 5);
      waitFetchAt(16'(a0 + 2));
      chkEq("R9 remaining elements", logCnt - base, 6);
      if (logCnt - base == 6) begin
        for (int i = 0; i < 3; i++) begin
          chkEq("R9 resumed destination", int'(lRt[base+3+i]), 42 + i);
          chkEq("R9 resumed first source", int'(lRa[base+3+i]), 52 + i);
          chkEq("R9 resumed second source", int'(lRb[base+3+i]), 62 + i);
        end
      end
      chkEq("R5 step cleared after resume", int'(curStep), 0);
    end

    finishRun();
  end

endmodule